// File: doc/BRIEF.md
# Register-Armed Memory Command Launcher

This unit sits between the system's memory access path and a low-power DRAM command sequencer. Software sends one device command at a time. It writes a control register with a command mode and a 6-bit device mode-register address, and it can read the value back before it fences. The command is not sent when the register is written. It is sent on the next write to any address of the memory space. That write only acknowledges the command and carries no data to memory.

Outside normal mode the memory path is held by the unit. Reads complete locally with zero data, and writes are absorbed. When normal mode is programmed again, accesses once more pass straight through to the memory controller.

The unit also handles results of device mode-register reads. When read data comes back, the unit stores it in the identification field that matches the address that was read. That field can be the manufacturer code, the first revision byte, the organisation byte, or the calibration-capability and default-auto-init bits.

Top module: `memcmd_launcher`

## Requirements
- R1: After reset the mode is normal (0), nothing is armed, `cmd_valid` is low, and every readable field reads as zero.
- R2: In normal mode (MODE=0) every memory access passes through unchanged. `dn_req`, `dn_we`, `dn_addr` and `dn_wdata` follow the upstream access, `mem_ack` equals `dn_ack`, and `mem_rdata` equals `dn_rdata`.
- R3: When MODE is not 0, a memory read is acknowledged in the same cycle with `mem_rdata` of zero and is not forwarded (`dn_req` stays low).
- R4: When MODE is not 0, a memory write is acknowledged in the same cycle and is never forwarded downstream.
- R5: Writing the control register (register index 0) with MODE field bits [2:0] = 1 arms a no-operation command. The next memory write raises `cmd_valid` for one cycle, one clock after that write, with `cmd_op` = 0.
- R6: With MODE=7 the launched operation depends on the address field, bits [13:8] of the control register. Address 63 gives reset (`cmd_op` 3), address 10 gives calibration (`cmd_op` 4), addresses 0, 5, 6 and 8 give a mode-register read (`cmd_op` 2), and any other address gives a mode-register write (`cmd_op` 1). `cmd_ma` carries the address.
- R7: `cmd_zq` carries the calibration type held in bits [1:0] of register index 1 at the moment of launch. Code 3 requests initialisation calibration and code 2 requests short calibration.
- R8: Each arming launches at most one command. Later memory writes launch nothing until the control register is written again.
- R9: A read of the control register returns the MODE and address fields that were last written, in the same bit positions.
- R10: Mode-register read data that returns for address 5 is stored in bits [7:0] of register index 2. Data for address 6 is stored in bits [15:8], and data for address 8 in bits [23:16].
- R11: Mode-register read data that returns for address 0 stores data bits [4:3] in bits [5:4] of register index 1 and data bit 0 in bit 16 of the control register. Other fields are unchanged.
- R12: MODE values 2 to 6 are non-normal, so R3 and R4 apply, but they arm nothing. A memory write in these modes launches no command.
- R13: A `mrr_valid` pulse that arrives when no mode-register read is outstanding changes no readable field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index (0 control, 1 calibration, 2 identification) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | input | 1 | Upstream memory access request |
| mem_we | input | 1 | Upstream access is a write |
| mem_addr | input | AW | Upstream access address |
| mem_wdata | input | DW | Upstream write data |
| mem_ack | output | 1 | Upstream access completion |
| mem_rdata | output | DW | Upstream read data |
| dn_req | output | 1 | Forwarded access request to memory controller |
| dn_we | output | 1 | Forwarded write flag |
| dn_addr | output | AW | Forwarded address |
| dn_wdata | output | DW | Forwarded write data |
| dn_ack | input | 1 | Completion from memory controller |
| dn_rdata | input | DW | Read data from memory controller |
| cmd_valid | output | 1 | One-cycle device command launch |
| cmd_op | output | 3 | Launched operation code |
| cmd_ma | output | 6 | Launched device mode-register address |
| cmd_zq | output | 2 | Calibration type with the launch |
| mrr_valid | input | 1 | Mode-register read data returned |
| mrr_data | input | 8 | Mode-register read data |

## Verification
The bench sends a memory write immediately after arming and checks the launch cycle. A design that launched on the register write, or whose launch came a cycle late, would miss the expected `cmd_valid` cycle. It then sends a second write without re-arming, which catches a launcher that fires on every write. It walks the address decode through reset, calibration with both calibration codes, the four read addresses and an ordinary write address, so a swapped or missing decode shows up as a wrong `cmd_op`. It feeds read data for each identification address and then a stray return with nothing outstanding. A design that routed by the wrong address, or that did not clear its pending read, would corrupt a field that the bench reads back.

// File: rtl/mcl_pkg.sv
// Package: shared constants, operation codes and decode helpers for the
// memory command launcher. Assumes a 32-bit register interface.
package mcl_pkg;

    localparam int REG_W   = 32;
    localparam int RADDR_W = 2;
    localparam int MODE_W  = 3;
    localparam int MA_W    = 6;
    localparam int ZQ_W    = 2;
    localparam int INFO_W  = 8;
    localparam int OP_W    = 3;

    // Register indices
    localparam logic [RADDR_W-1:0] RA_CTRL = 2'd0;
    localparam logic [RADDR_W-1:0] RA_CAL  = 2'd1;
    localparam logic [RADDR_W-1:0] RA_INFO = 2'd2;

    // Field positions inside the registers
    localparam int CTRL_MODE_LSB = 0;
    localparam int CTRL_MA_LSB   = 8;
    localparam int CTRL_DAI_BIT  = 16;
    localparam int CAL_ZQ_LSB    = 0;
    localparam int CAL_RZQI_LSB  = 4;
    localparam int INFO_MFR_LSB  = 0;
    localparam int INFO_REV_LSB  = 8;
    localparam int INFO_ORG_LSB  = 16;

    // Field positions inside returned mode-register data
    localparam int RD_RZQI_LSB = 3;
    localparam int RD_DAI_BIT  = 0;

    // Mode values
    localparam logic [MODE_W-1:0] MODE_NORMAL = 3'd0;
    localparam logic [MODE_W-1:0] MODE_NOP    = 3'd1;
    localparam logic [MODE_W-1:0] MODE_DEVCMD = 3'd7;

    // Device mode-register addresses with special meaning
    localparam logic [MA_W-1:0] MA_DEVINFO = 6'd0;
    localparam logic [MA_W-1:0] MA_MFR     = 6'd5;
    localparam logic [MA_W-1:0] MA_REV1    = 6'd6;
    localparam logic [MA_W-1:0] MA_ORG     = 6'd8;
    localparam logic [MA_W-1:0] MA_ZQCAL   = 6'd10;
    localparam logic [MA_W-1:0] MA_RESET   = 6'd63;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 3'd0,
        OP_MRW   = 3'd1,
        OP_MRR   = 3'd2,
        OP_RESET = 3'd3,
        OP_ZQCAL = 3'd4
    } cmd_op_e;

    // True for the modes that arm a launch
    function automatic logic mode_arms(input logic [MODE_W-1:0] m);
        return (m == MODE_NOP) || (m == MODE_DEVCMD);
    endfunction

    // True for addresses handled as device mode-register reads
    function automatic logic ma_is_read(input logic [MA_W-1:0] a);
        return (a == MA_DEVINFO) || (a == MA_MFR) || (a == MA_REV1) || (a == MA_ORG);
    endfunction

    // Operation selected by mode and address
    function automatic cmd_op_e decode_op(input logic [MODE_W-1:0] m,
                                          input logic [MA_W-1:0]   a);
        cmd_op_e op;
        if (m == MODE_NOP)          op = OP_NOP;
        else if (a == MA_RESET)     op = OP_RESET;
        else if (a == MA_ZQCAL)     op = OP_ZQCAL;
        else if (ma_is_read(a))     op = OP_MRR;
        else                        op = OP_MRW;
        return op;
    endfunction

endpackage

// File: rtl/mcl_ctrl_regs.sv
// Module: software-visible registers. Holds mode, address and calibration
// type, keeps the arm flag, and forms combinational read data.
// Assumes a register write and a launch can coincide; the write then wins
// for the arm flag.
module mcl_ctrl_regs
    import mcl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [RADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic                 launch,
    input  logic [INFO_W-1:0]    info_mfr,
    input  logic [INFO_W-1:0]    info_rev,
    input  logic [INFO_W-1:0]    info_org,
    input  logic [1:0]           info_rzqi,
    input  logic                 info_dai,
    output logic [MODE_W-1:0]    mode_o,
    output logic [MA_W-1:0]      ma_o,
    output logic [ZQ_W-1:0]      zq_o,
    output logic                 armed_o
);

    logic                wr_ctrl;
    logic                wr_cal;
    logic [MODE_W-1:0]   wr_mode;
    logic [MA_W-1:0]     wr_ma;
    logic                unused_wbits;

    assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
    assign wr_cal  = reg_wr && (reg_addr == RA_CAL);
    assign wr_mode = reg_wdata[CTRL_MODE_LSB +: MODE_W];
    assign wr_ma   = reg_wdata[CTRL_MA_LSB +: MA_W];
    assign unused_wbits = ^{reg_wdata[REG_W-1:CTRL_MA_LSB+MA_W],
                            reg_wdata[CTRL_MA_LSB-1:MODE_W]};

    // Control fields and arm flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o  <= MODE_NORMAL;
            ma_o    <= '0;
            armed_o <= 1'b0;
        end else begin
            if (launch) begin
                armed_o <= 1'b0;
            end
            if (wr_ctrl) begin
                mode_o  <= wr_mode;
                ma_o    <= wr_ma;
                armed_o <= mode_arms(wr_mode);
            end
        end
    end

    // Calibration type
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zq_o <= '0;
        end else if (wr_cal) begin
            zq_o <= reg_wdata[CAL_ZQ_LSB +: ZQ_W];
        end
    end

    // Read-data multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CTRL_MODE_LSB +: MODE_W] = mode_o;
                reg_rdata[CTRL_MA_LSB +: MA_W]     = ma_o;
                reg_rdata[CTRL_DAI_BIT]            = info_dai;
            end
            RA_CAL: begin
                reg_rdata[CAL_ZQ_LSB +: ZQ_W]  = zq_o;
                reg_rdata[CAL_RZQI_LSB +: 2]   = info_rzqi;
            end
            RA_INFO: begin
                reg_rdata[INFO_MFR_LSB +: INFO_W] = info_mfr;
                reg_rdata[INFO_REV_LSB +: INFO_W] = info_rev;
                reg_rdata[INFO_ORG_LSB +: INFO_W] = info_org;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mcl_access_path.sv
// Module: memory access path. Passes accesses through in normal mode,
// completes them locally otherwise, and turns an armed write into a
// one-cycle command launch registered one clock later.
// Assumes the downstream side accepts a request in the cycle it is shown.
module mcl_access_path
    import mcl_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MODE_W-1:0]  mode,
    input  logic [MA_W-1:0]    ma,
    input  logic [ZQ_W-1:0]    zq,
    input  logic               armed,
    input  logic               mem_req,
    input  logic               mem_we,
    input  logic [AW-1:0]      mem_addr,
    input  logic [DW-1:0]      mem_wdata,
    output logic               mem_ack,
    output logic [DW-1:0]      mem_rdata,
    output logic               dn_req,
    output logic               dn_we,
    output logic [AW-1:0]      dn_addr,
    output logic [DW-1:0]      dn_wdata,
    input  logic               dn_ack,
    input  logic [DW-1:0]      dn_rdata,
    output logic               launch,
    output cmd_op_e            launch_op,
    output logic               cmd_valid,
    output logic [OP_W-1:0]    cmd_op,
    output logic [MA_W-1:0]    cmd_ma,
    output logic [ZQ_W-1:0]    cmd_zq
);

    logic normal;

    assign normal    = (mode == MODE_NORMAL);
    assign launch    = !normal && armed && mem_req && mem_we;
    assign launch_op = decode_op(mode, ma);

    // Pass-through or local completion of the upstream access
    always_comb begin
        if (normal) begin
            dn_req    = mem_req;
            dn_we     = mem_we;
            dn_addr   = mem_addr;
            dn_wdata  = mem_wdata;
            mem_ack   = dn_ack;
            mem_rdata = dn_rdata;
        end else begin
            dn_req    = 1'b0;
            dn_we     = 1'b0;
            dn_addr   = '0;
            dn_wdata  = '0;
            mem_ack   = mem_req;
            mem_rdata = '0;
        end
    end

    // Launch strobe, one cycle after the acknowledging write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= launch;
        end
    end

    // Command fields, captured at launch and held afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_op <= '0;
            cmd_ma <= '0;
            cmd_zq <= '0;
        end else if (launch) begin
            cmd_op <= launch_op;
            cmd_ma <= ma;
            cmd_zq <= zq;
        end
    end

endmodule

// File: rtl/mcl_mrr_capture.sv
// Module: captures returned mode-register read data. The address of the
// outstanding read is latched at launch, and the returned byte is stored
// in the field matching that address. Assumes at most one read is
// outstanding; a new read launch replaces the pending address.
module mcl_mrr_capture
    import mcl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  cmd_op_e            launch_op,
    input  logic [MA_W-1:0]    ma,
    input  logic               mrr_valid,
    input  logic [INFO_W-1:0]  mrr_data,
    output logic [INFO_W-1:0]  info_mfr,
    output logic [INFO_W-1:0]  info_rev,
    output logic [INFO_W-1:0]  info_org,
    output logic [1:0]         info_rzqi,
    output logic               info_dai
);

    localparam int N_ID = 3;

    // Address feeding each identification field
    function automatic logic [MA_W-1:0] id_addr(input int i);
        case (i)
            0:       return MA_MFR;
            1:       return MA_REV1;
            default: return MA_ORG;
        endcase
    endfunction

    logic                   pend;
    logic [MA_W-1:0]        pend_ma;
    logic                   take;
    logic [N_ID*INFO_W-1:0] id_flat;

    assign take = mrr_valid && pend;

    // Outstanding-read tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            pend_ma <= '0;
        end else if (launch && (launch_op == OP_MRR)) begin
            pend    <= 1'b1;
            pend_ma <= ma;
        end else if (take) begin
            pend    <= 1'b0;
        end
    end

    // One identification byte per address
    for (genvar g = 0; g < N_ID; g++) begin : g_id
        logic [INFO_W-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (take && (pend_ma == id_addr(g))) begin
                q <= mrr_data;
            end
        end
        assign id_flat[g*INFO_W +: INFO_W] = q;
    end

    assign info_mfr = id_flat[0*INFO_W +: INFO_W];
    assign info_rev = id_flat[1*INFO_W +: INFO_W];
    assign info_org = id_flat[2*INFO_W +: INFO_W];

    // Calibration capability and auto-init bits from address 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            info_rzqi <= '0;
            info_dai  <= 1'b0;
        end else if (take && (pend_ma == MA_DEVINFO)) begin
            info_rzqi <= mrr_data[RD_RZQI_LSB +: 2];
            info_dai  <= mrr_data[RD_DAI_BIT];
        end
    end

endmodule

// File: rtl/memcmd_launcher.sv
// Module: top of the register-armed memory command launcher. Connects the
// register block, the memory access path and the read-data capture.
// Assumes single-cycle register accesses and single-cycle upstream requests.
module memcmd_launcher
    import mcl_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               mem_req,
    input  logic               mem_we,
    input  logic [AW-1:0]      mem_addr,
    input  logic [DW-1:0]      mem_wdata,
    output logic               mem_ack,
    output logic [DW-1:0]      mem_rdata,
    output logic               dn_req,
    output logic               dn_we,
    output logic [AW-1:0]      dn_addr,
    output logic [DW-1:0]      dn_wdata,
    input  logic               dn_ack,
    input  logic [DW-1:0]      dn_rdata,
    output logic               cmd_valid,
    output logic [2:0]         cmd_op,
    output logic [5:0]         cmd_ma,
    output logic [1:0]         cmd_zq,
    input  logic               mrr_valid,
    input  logic [7:0]         mrr_data
);

    logic [MODE_W-1:0] cur_mode;
    logic [MA_W-1:0]   cur_ma;
    logic [ZQ_W-1:0]   cur_zq;
    logic              armed;
    logic              launch;
    cmd_op_e           launch_op;
    logic [INFO_W-1:0] info_mfr;
    logic [INFO_W-1:0] info_rev;
    logic [INFO_W-1:0] info_org;
    logic [1:0]        info_rzqi;
    logic              info_dai;

    mcl_ctrl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .launch    (launch),
        .info_mfr  (info_mfr),
        .info_rev  (info_rev),
        .info_org  (info_org),
        .info_rzqi (info_rzqi),
        .info_dai  (info_dai),
        .mode_o    (cur_mode),
        .ma_o      (cur_ma),
        .zq_o      (cur_zq),
        .armed_o   (armed)
    );

    mcl_access_path #(.AW(AW), .DW(DW)) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (cur_mode),
        .ma        (cur_ma),
        .zq        (cur_zq),
        .armed     (armed),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .dn_req    (dn_req),
        .dn_we     (dn_we),
        .dn_addr   (dn_addr),
        .dn_wdata  (dn_wdata),
        .dn_ack    (dn_ack),
        .dn_rdata  (dn_rdata),
        .launch    (launch),
        .launch_op (launch_op),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_ma    (cmd_ma),
        .cmd_zq    (cmd_zq)
    );

    mcl_mrr_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .launch_op (launch_op),
        .ma        (cur_ma),
        .mrr_valid (mrr_valid),
        .mrr_data  (mrr_data),
        .info_mfr  (info_mfr),
        .info_rev  (info_rev),
        .info_org  (info_org),
        .info_rzqi (info_rzqi),
        .info_dai  (info_dai)
    );

endmodule

// File: rtl/mcl_checker.sv
// Checker: temporal properties of the launcher, bound to the top module.
module mcl_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [1:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [DW-1:0] mem_rdata,
    input logic          dn_req,
    input logic          dn_ack,
    input logic          cmd_valid,
    input logic [2:0]    mode,
    input logic          armed
);

    // R1: reset clears launch, arm and mode
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!cmd_valid && !armed && mode == 3'd0));

    // R2: normal mode passes request and completion straight through
    p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0) |-> (dn_req == mem_req && mem_ack == dn_ack));

    // R3: reads outside normal mode complete locally with zero data
    p_local_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 3'd0 && mem_req && !mem_we) |-> (mem_ack && mem_rdata == '0));

    // R4: nothing is forwarded outside normal mode
    p_no_forward_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 3'd0) |-> !dn_req);

    // R5: an armed write launches on the next clock
    p_launch_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 3'd0 && armed && mem_req && mem_we) |=> cmd_valid);

    // R8: after a launch the unit is disarmed unless re-armed in that cycle
    p_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !$past(reg_wr && reg_addr == 2'd0)) |-> !armed);

    // R12: modes other than 1 and 7 leave the unit disarmed
    p_no_arm_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && reg_wdata[2:0] != 3'd1 && reg_wdata[2:0] != 3'd7)
        |=> !armed);

endmodule

bind memcmd_launcher mcl_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .dn_req    (dn_req),
    .dn_ack    (dn_ack),
    .cmd_valid (cmd_valid),
    .mode      (cur_mode),
    .armed     (armed)
);

// File: tb/memcmd_launcher_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model stepped on every clock and compared
// with all outputs in the middle of the low clock phase.
module memcmd_launcher_tb_top;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CLK_HALF = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_wr;
    logic [1:0]    reg_addr;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack;
    logic [DW-1:0] mem_rdata;
    logic          dn_req, dn_we;
    logic [AW-1:0] dn_addr;
    logic [DW-1:0] dn_wdata;
    logic          dn_ack;
    logic [DW-1:0] dn_rdata;
    logic          cmd_valid;
    logic [2:0]    cmd_op;
    logic [5:0]    cmd_ma;
    logic [1:0]    cmd_zq;
    logic          mrr_valid;
    logic [7:0]    mrr_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #CLK_HALF clk = ~clk;

    memcmd_launcher #(.AW(AW), .DW(DW)) dut_i (.*);

    // Reference model state
    int m_mode, m_ma, m_zq, m_armed, m_pend, m_pend_ma;
    int m_mfr, m_rev, m_org, m_rzqi, m_dai;
    int m_cv, m_op, m_cma, m_czq;

    function automatic int model_op(int mode, int ma);
        if (mode == 1) return 0;
        if (ma == 63) return 3;
        if (ma == 10) return 4;
        if (ma == 0 || ma == 5 || ma == 6 || ma == 8) return 2;
        return 1;
    endfunction

    task automatic model_reset();
        m_mode = 0; m_ma = 0; m_zq = 0; m_armed = 0; m_pend = 0; m_pend_ma = 0;
        m_mfr = 0; m_rev = 0; m_org = 0; m_rzqi = 0; m_dai = 0;
        m_cv = 0; m_op = 0; m_cma = 0; m_czq = 0;
    endtask

    // Advance the model by one clock using the current inputs
    task automatic model_step();
        int fire;
        if (!rst_n) begin
            model_reset();
            return;
        end
        fire = (m_mode != 0 && m_armed != 0 && mem_req && mem_we) ? 1 : 0;
        if (mrr_valid && m_pend != 0) begin
            case (m_pend_ma)
                5: m_mfr = mrr_data;
                6: m_rev = mrr_data;
                8: m_org = mrr_data;
                0: begin m_rzqi = (mrr_data >> 3) & 3; m_dai = mrr_data & 1; end
                default: ;
            endcase
            m_pend = 0;
        end
        m_cv = fire;
        if (fire != 0) begin
            m_op  = model_op(m_mode, m_ma);
            m_cma = m_ma;
            m_czq = m_zq;
            m_armed = 0;
            if (m_op == 2) begin m_pend = 1; m_pend_ma = m_ma; end
        end
        if (reg_wr && reg_addr == 2'd0) begin
            m_mode  = reg_wdata & 7;
            m_ma    = (reg_wdata >> 8) & 63;
            m_armed = (m_mode == 1 || m_mode == 7) ? 1 : 0;
        end
        if (reg_wr && reg_addr == 2'd1) m_zq = reg_wdata & 3;
    endtask

    function automatic logic [31:0] model_rdata(logic [1:0] a);
        case (a)
            2'd0: return 32'((m_dai << 16) | (m_ma << 8) | m_mode);
            2'd1: return 32'((m_rzqi << 4) | m_zq);
            2'd2: return 32'((m_org << 16) | (m_rev << 8) | m_mfr);
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        logic exp_dn;
        exp_dn = (m_mode == 0) ? mem_req : 1'b0;
        chk(tag, "dn_req", 32'(dn_req), 32'(exp_dn));
        if (exp_dn) begin
            chk(tag, "dn_we", 32'(dn_we), 32'(mem_we));
            chk(tag, "dn_addr", dn_addr, mem_addr);
            chk(tag, "dn_wdata", dn_wdata, mem_wdata);
        end
        chk(tag, "mem_ack", 32'(mem_ack), 32'((m_mode == 0) ? dn_ack : mem_req));
        chk(tag, "mem_rdata", mem_rdata, (m_mode == 0) ? dn_rdata : 32'd0);
        chk(tag, "cmd_valid", 32'(cmd_valid), 32'(m_cv));
        if (m_cv != 0) begin
            chk(tag, "cmd_op", 32'(cmd_op), 32'(m_op));
            chk(tag, "cmd_ma", 32'(cmd_ma), 32'(m_cma));
            chk(tag, "cmd_zq", 32'(cmd_zq), 32'(m_czq));
        end
        chk(tag, "reg_rdata", reg_rdata, model_rdata(reg_addr));
    endtask

    // One clock: compare mid-low-phase, step model at the edge
    task automatic tick(string tag);
        #(CLK_HALF/2);
        compare(tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle();
        reg_wr = 0; reg_addr = 2'd0; reg_wdata = '0;
        mem_req = 0; mem_we = 0; mem_addr = '0; mem_wdata = '0;
        dn_ack = 1; dn_rdata = 32'h1357_9bdf;
        mrr_valid = 0; mrr_data = '0;
    endtask

    task automatic reg_write(logic [1:0] a, logic [31:0] d, string tag);
        idle(); reg_wr = 1; reg_addr = a; reg_wdata = d; tick(tag);
    endtask

    task automatic peek(logic [1:0] a, string tag);
        idle(); reg_addr = a; tick(tag);
    endtask

    task automatic mem_op(logic we, logic [31:0] a, logic [31:0] d, string tag);
        idle(); mem_req = 1; mem_we = we; mem_addr = a; mem_wdata = d; tick(tag);
    endtask

    task automatic quiet(string tag);
        idle(); tick(tag);
    endtask

    task automatic mrr_return(logic [7:0] d, string tag);
        idle(); mrr_valid = 1; mrr_data = d; tick(tag);
    endtask

    // Arm a mode-7 command and acknowledge it with a memory write
    task automatic dev_cmd(int ma, string tag);
        reg_write(2'd0, 32'((ma << 8) | 7), tag);
        peek(2'd0, "R9");
        mem_op(1, 32'h0000_0400, 32'hdead_beef, tag);
        quiet(tag);
    endtask

    initial begin
        model_reset();
        idle();
        rst_n = 0;
        @(negedge clk);
        tick("R1");
        tick("R1");
        rst_n = 1;
        peek(2'd0, "R1"); peek(2'd1, "R1"); peek(2'd2, "R1");

        // Normal-mode pass-through, including a stalled completion
        mem_op(0, 32'h0000_1000, 32'h0, "R2");
        idle(); mem_req = 1; mem_addr = 32'h2000; dn_ack = 0; dn_rdata = 32'h0bad_f00d; tick("R2");
        mem_op(1, 32'h0000_2004, 32'h1234_5678, "R2");

        // NOP command
        reg_write(2'd0, 32'h0000_0001, "R9");
        peek(2'd0, "R9");
        mem_op(0, 32'h0000_3000, 32'h0, "R3");
        mem_op(1, 32'h0000_3004, 32'haaaa_5555, "R5");
        quiet("R5");
        mem_op(1, 32'h0000_3008, 32'h5555_aaaa, "R8");
        quiet("R8");
        mem_op(1, 32'h0000_300c, 32'h0, "R4");
        quiet("R8");

        // Reset, calibration with both codes, ordinary write
        dev_cmd(63, "R6");
        reg_write(2'd1, 32'd3, "R7");
        dev_cmd(10, "R7");
        reg_write(2'd1, 32'd2, "R7");
        peek(2'd1, "R7");
        dev_cmd(10, "R7");
        dev_cmd(1, "R6");
        dev_cmd(16, "R6");

        // Mode-register reads and result routing
        dev_cmd(5, "R6");
        mrr_return(8'h5a, "R10");
        peek(2'd2, "R10");
        dev_cmd(6, "R10");
        mrr_return(8'h31, "R10");
        dev_cmd(8, "R10");
        mrr_return(8'h9c, "R10");
        peek(2'd2, "R10");
        dev_cmd(0, "R11");
        mrr_return(8'b0001_1001, "R11");
        peek(2'd1, "R11");
        peek(2'd0, "R11");

        // Stray read data with nothing outstanding
        mrr_return(8'hff, "R13");
        peek(2'd2, "R13");
        peek(2'd1, "R13");
        peek(2'd0, "R13");

        // Non-arming non-normal mode
        reg_write(2'd0, 32'h0000_0503, "R12");
        mem_op(1, 32'h0000_4000, 32'h1, "R12");
        quiet("R12");
        mem_op(0, 32'h0000_4004, 32'h0, "R12");

        // Back to normal
        reg_write(2'd0, 32'h0000_0000, "R2");
        mem_op(0, 32'h0000_5000, 32'h0, "R2");
        mem_op(1, 32'h0000_5004, 32'hcafe_0001, "R2");
        quiet("R2");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(2 * CLK_HALF * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule